// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block sequences detection and sampling for a four-wire resistive touch panel. While the controller is enabled it keeps the panel drive lines on in detection mode and watches a raw contact comparator. When contact appears it first waits a coded settling time and then a debounce window. If contact holds for the whole window, the pen is declared down. While the pen stays down, the block launches one coordinate conversion per scan period and examines contact once per period. After a programmed number of consecutive periods without contact, it declares the pen up.

All timing comes from a one-microsecond tick input, so an integrator or a testbench can scale time freely. The four timing settings arrive as one 32-bit control word. Pen state is reported as a level, and every change of that level also produces a one-cycle event pulse for an interrupt controller. The analog front end and the converter sit outside the block. The converter reports the end of each burst with a done strobe.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, pen_down, pen_evt and conv_start are 0. While ctl_en is 0, drive_en is also 0.
- R2: Control word fields:
  - bits 31:24 hold the scan period;
  - bits 23:16 hold the debounce length;
  - bits 15:8 hold the settling code;
  - bits 7:0 hold the touch timeout.
  - The package constant for the reset configuration equals 32'h0528_070A.
- R3: Settling code 0 waits 8 ticks. Code k from 1 to 11 waits 10·2^(k-1) ticks, which is 10240 ticks for code 11. Codes above 11 wait as code 11 does.
- R4: The debounce window lasts field·DEB_STEP_US ticks, and a field of 0 means no wait. With us_tick high every cycle, pen_down rises exactly SYNC_STAGES+3+settle+debounce cycles after the first clock edge that sees contact high.
- R5: If contact is lost during the debounce window, the block returns to idle without a pen event. A later contact must go through the full settle and debounce wait again.
- R6: pen_evt is a one-cycle pulse. It occurs in exactly those cycles in which pen_down differs from its value in the cycle before.
- R7: A conversion start pulse fires in the cycle pen_down rises. While contact holds, one more fires every scan period: field·SCAN_STEP_US ticks, with a field of 0 meaning 256 steps.
- R8: The block ends a touch on the max(timeout,1)-th consecutive scan sample without contact. pen_down then falls exactly max(timeout,1)·period cycles after the last conversion start.
- R9: drive_en is 0 while a conversion is in flight, meaning from conv_start until conv_done. A scan period that ends during a conversion takes no sample: it neither starts a conversion nor counts a miss.
- R10: When ctl_en goes low, drive_en goes low at once. On the next edge the block is idle and the pen is up, with a pen event if the pen was down. No conversions start while ctl_en is low.
- R11: The settle, debounce and scan timers advance only on cycles with us_tick high. With the tick held low, no touch is ever declared.
- R12: conv_start is a single-cycle pulse and occurs only while pen_down is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| cfg_word | input | 32 | Timing fields: scan, debounce, settle code, timeout |
| us_tick | input | 1 | One-microsecond time base strobe |
| contact_raw | input | 1 | Asynchronous panel contact comparator |
| conv_done | input | 1 | Converter burst finished |
| drive_en | output | 1 | Panel drive lines on (detection mode) |
| conv_start | output | 1 | Start one coordinate conversion burst |
| pen_down | output | 1 | Pen contact status |
| pen_evt | output | 1 | Pen down/up change pulse |

## Verification
The bench measures the touch latency exactly for several settling codes, including the clamped code above 11, so an off-by-one in the settle table, the debounce scaling or the synchronizer depth shows up as a wrong cycle count. It checks that a scan field of 0 yields a 256-step period, and that a timeout of 0 ends a touch on the first missed sample; a design that treated 0 literally would stop scanning or never release the pen. A contact dropped mid-debounce must produce no event and must restart the full wait; a design that resumed the debounce would touch down early. A conversion that never completes must freeze sampling rather than count misses, and disabling the controller mid-touch must release the pen with an event.

// File: rtl/tss_pkg.sv
package tss_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_SETTLE   = 2'd1,
      ST_DEBOUNCE = 2'd2,
      ST_TOUCHED  = 2'd3
   } tss_state_e;

   localparam int FIELD_W = 8;

   // Field order matches the control word: scan in the top byte, timeout in the bottom byte.
   typedef struct packed {
      logic [FIELD_W-1:0] scan;
      logic [FIELD_W-1:0] deb;
      logic [FIELD_W-1:0] settle;
      logic [FIELD_W-1:0] tmo;
   } tss_cfg_t;

   localparam logic [31:0] TSS_CFG_RESET = 32'h0528_070A;

   localparam int SETTLE_MAX_CODE = 11;
   localparam int SETTLE_CODE0_US = 8;
   localparam int SETTLE_BASE_US  = 10;
   localparam int SETTLE_MAX_US   = SETTLE_BASE_US << (SETTLE_MAX_CODE - 1);
   localparam int SCAN_MAX_STEPS  = 256;

   // Settling wait in microsecond ticks; codes past the top of the table clamp.
   function automatic logic [31:0] settle_ticks(input logic [FIELD_W-1:0] code);
      logic [FIELD_W-1:0] c;
      if (code == '0) return 32'(SETTLE_CODE0_US);
      c = (code > FIELD_W'(SETTLE_MAX_CODE)) ? FIELD_W'(SETTLE_MAX_CODE) : code;
      return 32'(SETTLE_BASE_US) << (c - FIELD_W'(1));
   endfunction

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tss_timer.sv
module tss_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (load)                  cnt <= load_val;
      else if (tick && cnt != '0)     cnt <= cnt - W'(1);
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/tss_fsm.sv
module tss_fsm
   import tss_pkg::*;
#(
   parameter int TMR_W        = 16,
   parameter int SCAN_STEP_US = 1024,
   parameter int DEB_STEP_US  = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_en,
   input  tss_cfg_t         cfg,
   input  logic             contact,
   input  logic             conv_done,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val,
   output logic             pen_down,
   output logic             pen_evt,
   output logic             conv_start,
   output logic             busy
);
   localparam int MISS_W = FIELD_W + 1;

   tss_state_e        state, nxt_state;
   logic [MISS_W-1:0] miss_cnt;
   logic [MISS_W-1:0] miss_limit;
   logic [8:0]        scan_steps;
   logic [31:0]       scan_ticks, deb_ticks, set_ticks;
   logic              go_touch, fire_conv, miss_inc, miss_clr, go_release;

   always_comb begin
      scan_steps = (cfg.scan == '0) ? 9'(SCAN_MAX_STEPS) : {1'b0, cfg.scan};
      scan_ticks = 32'(scan_steps) * 32'(SCAN_STEP_US) - 32'd1;
      deb_ticks  = 32'(cfg.deb) * 32'(DEB_STEP_US);
      set_ticks  = settle_ticks(cfg.settle);
      miss_limit = (cfg.tmo == '0) ? MISS_W'(1) : {1'b0, cfg.tmo};
   end

   always_comb begin
      nxt_state  = state;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      go_touch   = 1'b0;
      fire_conv  = 1'b0;
      miss_inc   = 1'b0;
      miss_clr   = 1'b0;
      go_release = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (contact) begin
               nxt_state = ST_SETTLE;
               tmr_load  = 1'b1;
               tmr_val   = TMR_W'(set_ticks);
            end
         end
         ST_SETTLE: begin
            if (tmr_done) begin
               nxt_state = ST_DEBOUNCE;
               tmr_load  = 1'b1;
               tmr_val   = TMR_W'(deb_ticks);
            end
         end
         ST_DEBOUNCE: begin
            if (!contact) begin
               nxt_state = ST_IDLE;
            end else if (tmr_done) begin
               nxt_state = ST_TOUCHED;
               go_touch  = 1'b1;
               fire_conv = 1'b1;
               miss_clr  = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = TMR_W'(scan_ticks);
            end
         end
         ST_TOUCHED: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(scan_ticks);
               if (busy) begin
                  // conversion still running: this period takes no sample
               end else if (contact) begin
                  fire_conv = 1'b1;
                  miss_clr  = 1'b1;
               end else if ((miss_cnt + MISS_W'(1)) >= miss_limit) begin
                  nxt_state  = ST_IDLE;
                  go_release = 1'b1;
                  tmr_load   = 1'b0;
               end else begin
                  miss_inc = 1'b1;
               end
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         miss_cnt   <= '0;
         pen_down   <= 1'b0;
         pen_evt    <= 1'b0;
         conv_start <= 1'b0;
         busy       <= 1'b0;
      end else begin
         pen_evt    <= 1'b0;
         conv_start <= 1'b0;
         if (!ctl_en) begin
            state    <= ST_IDLE;
            miss_cnt <= '0;
            busy     <= 1'b0;
            if (pen_down) begin
               pen_down <= 1'b0;
               pen_evt  <= 1'b1;
            end
         end else begin
            state <= nxt_state;
            if (conv_done) busy <= 1'b0;
            if (fire_conv) begin
               conv_start <= 1'b1;
               busy       <= 1'b1;
            end
            if (miss_clr)      miss_cnt <= '0;
            else if (miss_inc) miss_cnt <= miss_cnt + MISS_W'(1);
            if (go_touch) begin
               pen_down <= 1'b1;
               pen_evt  <= 1'b1;
            end
            if (go_release) begin
               pen_down <= 1'b0;
               pen_evt  <= 1'b1;
               miss_cnt <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
   import tss_pkg::*;
#(
   parameter int SCAN_STEP_US = 1024,
   parameter int DEB_STEP_US  = 512,
   parameter int SYNC_STAGES  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_en,
   input  logic [31:0] cfg_word,
   input  logic        us_tick,
   input  logic        contact_raw,
   input  logic        conv_done,
   output logic        drive_en,
   output logic        conv_start,
   output logic        pen_down,
   output logic        pen_evt
);
   localparam int SCAN_MAX = SCAN_MAX_STEPS * SCAN_STEP_US;
   localparam int DEB_MAX  = ((1 << FIELD_W) - 1) * DEB_STEP_US;
   localparam int MAX_AB   = (SCAN_MAX > DEB_MAX) ? SCAN_MAX : DEB_MAX;
   localparam int TMR_MAX  = (MAX_AB > SETTLE_MAX_US) ? MAX_AB : SETTLE_MAX_US;
   localparam int TMR_W    = $clog2(TMR_MAX + 1);

   generate
      if (SCAN_STEP_US < 1) begin : g_bad_scan
         $error("SCAN_STEP_US must be at least 1");
      end
      if (DEB_STEP_US < 1) begin : g_bad_deb
         $error("DEB_STEP_US must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   tss_cfg_t         cfg;
   logic             contact_s;
   logic             tmr_load, tmr_done, busy;
   logic [TMR_W-1:0] tmr_val;

   assign cfg = tss_cfg_t'(cfg_word);

   tss_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (contact_raw),
      .q_sync  (contact_s)
   );

   tss_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .tick     (us_tick),
      .done     (tmr_done)
   );

   tss_fsm #(
      .TMR_W        (TMR_W),
      .SCAN_STEP_US (SCAN_STEP_US),
      .DEB_STEP_US  (DEB_STEP_US)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_en     (ctl_en),
      .cfg        (cfg),
      .contact    (contact_s),
      .conv_done  (conv_done),
      .tmr_done   (tmr_done),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .pen_down   (pen_down),
      .pen_evt    (pen_evt),
      .conv_start (conv_start),
      .busy       (busy)
   );

   assign drive_en = ctl_en & ~busy;
endmodule

// File: rtl/tss_checker.sv
module tss_checker (
   input logic clk,
   input logic rst_n,
   input logic ctl_en,
   input logic drive_en,
   input logic conv_start,
   input logic pen_down,
   input logic pen_evt
);
   // R6: event only on a change of pen state
   a_r6_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      pen_evt |-> !$stable(pen_down));
   // R6: every change of pen state carries an event
   a_r6_change_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pen_down) |-> pen_evt);
   // R12: conversions only while the pen is down
   a_r12_conv_needs_pen: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> pen_down);
   // R12: conversion start is a single-cycle pulse
   a_r12_conv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R9: drives released while a conversion runs
   a_r9_drive_off_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !drive_en);
   // R10: disabling releases the pen on the next edge
   a_r10_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> !pen_down);
   // R10: no drive while disabled
   a_r10_no_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> !drive_en);
endmodule

bind touch_scan_seq tss_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_en     (ctl_en),
   .drive_en   (drive_en),
   .conv_start (conv_start),
   .pen_down   (pen_down),
   .pen_evt    (pen_evt)
);

// File: tb/touch_scan_seq_test.sv
module touch_scan_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int SCAN_STEP  = 16;
   localparam int DEB_STEP   = 8;
   localparam int SYNC       = 2;
   localparam int NVEC       = 5;

   // {control word, expected touch latency, expected scan period}
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0100_0000, 16'd13,    16'd16},
      {32'h0302_0102, 16'd31,    16'd48},
      {32'h0001_0301, 16'd53,    16'd4096},
      {32'h0205_0C03, 16'd10285, 16'd32},
      {32'h0528_070A, 16'd965,   16'd80}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_en = 1'b0;
   logic [31:0] cfg_word = 32'h0;
   logic        us_tick = 1'b1;
   logic        contact_raw = 1'b0;
   logic        done_auto = 1'b0;
   logic        done_man = 1'b0;
   logic        conv_done;
   logic        drive_en, conv_start, pen_down, pen_evt;
   bit          auto_done = 1'b1;
   int          checks = 0;
   int          errors = 0;
   int          evt_cnt = 0;
   int          conv_cnt = 0;

   assign conv_done = done_auto | done_man;

   always #(CLK_PERIOD/2) clk = ~clk;

   touch_scan_seq #(
      .SCAN_STEP_US (SCAN_STEP),
      .DEB_STEP_US  (DEB_STEP),
      .SYNC_STAGES  (SYNC)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_en      (ctl_en),
      .cfg_word    (cfg_word),
      .us_tick     (us_tick),
      .contact_raw (contact_raw),
      .conv_done   (conv_done),
      .drive_en    (drive_en),
      .conv_start  (conv_start),
      .pen_down    (pen_down),
      .pen_evt     (pen_evt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_pen(input logic lvl, input int limit, output int n);
      n = 0;
      do begin
         @(posedge clk); n++; @(negedge clk);
      end while (pen_down !== lvl && n < limit);
   endtask

   task automatic wait_conv(input int limit, output int n);
      n = 0;
      do begin
         @(posedge clk); n++; @(negedge clk);
      end while (conv_start !== 1'b1 && n < limit);
   endtask

   // observation of pulses
   initial forever begin
      @(negedge clk);
      if (pen_evt === 1'b1) evt_cnt++;
      if (conv_start === 1'b1) conv_cnt++;
   end

   // converter model: done two cycles after each start
   initial forever begin
      @(negedge clk);
      if (auto_done && conv_start === 1'b1) begin
         repeat (2) @(negedge clk);
         done_auto = 1'b1;
         @(negedge clk);
         done_auto = 1'b0;
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n, e0, c0, tmo, per, exp_up;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "pen_down after reset", pen_down, 0);
      chk("R1", "pen_evt after reset", pen_evt, 0);
      chk("R1", "conv_start after reset", conv_start, 0);
      chk("R1", "drive_en while disabled", drive_en, 0);
      // R2 reset configuration constant
      chk("R2", "reset config constant", int'(tss_pkg::TSS_CFG_RESET), int'(32'h0528_070A));

      ctl_en = 1'b1;
      @(negedge clk);
      chk("R10", "drive_en when enabled and idle", drive_en, 1);
      repeat (30) @(negedge clk);
      chk("R4", "no touch without contact", pen_down, 0);

      // table walk: R3 R4 R7 R8 R6
      for (int i = 0; i < NVEC; i++) begin
         cfg_word = VEC[i][63:32];
         tmo      = int'(cfg_word[7:0]);
         per      = int'(VEC[i][15:0]);
         exp_up   = ((tmo == 0) ? 1 : tmo) * per;
         @(negedge clk);
         contact_raw = 1'b1;
         wait_pen(1'b1, 20000, n);
         chk("R3/R4", $sformatf("vec%0d touch latency", i), n, int'(VEC[i][31:16]));
         chk("R6", $sformatf("vec%0d down event", i), pen_evt, 1);
         chk("R7", $sformatf("vec%0d first conversion", i), conv_start, 1);
         wait_conv(6000, n);
         chk("R7", $sformatf("vec%0d scan period", i), n, per);
         contact_raw = 1'b0;
         wait_pen(1'b0, 70000, n);
         chk("R8", $sformatf("vec%0d release delay", i), n, exp_up);
         chk("R6", $sformatf("vec%0d up event", i), pen_evt, 1);
         repeat (5) @(negedge clk);
      end

      // R5 contact lost during debounce
      cfg_word = {8'd1, 8'd4, 8'd0, 8'd0};
      e0 = evt_cnt;
      contact_raw = 1'b1;
      repeat (20) @(negedge clk);
      contact_raw = 1'b0;
      repeat (60) @(negedge clk);
      chk("R5", "no event on debounce drop", evt_cnt, e0);
      chk("R5", "pen stays up on debounce drop", pen_down, 0);
      contact_raw = 1'b1;
      wait_pen(1'b1, 2000, n);
      chk("R5", "full wait after debounce drop", n, SYNC + 3 + 8 + 32);
      contact_raw = 1'b0;
      wait_pen(1'b0, 2000, n);
      repeat (5) @(negedge clk);

      // R11 tick gating, then R9 stalled conversion
      cfg_word = {8'd1, 8'd0, 8'd0, 8'd0};
      auto_done = 1'b0;
      us_tick = 1'b0;
      contact_raw = 1'b1;
      repeat (200) @(negedge clk);
      chk("R11", "no touch without ticks", pen_down, 0);
      us_tick = 1'b1;
      wait_pen(1'b1, 2000, n);
      chk("R11", "latency after ticks resume", n, 10);
      contact_raw = 1'b0;
      @(negedge clk);
      chk("R9", "drive off during conversion", drive_en, 0);
      c0 = conv_cnt;
      repeat (100) @(negedge clk);
      chk("R9", "no miss counted during conversion", pen_down, 1);
      chk("R9", "no new conversion while busy", conv_cnt, c0);
      chk("R9", "drive still off while busy", drive_en, 0);
      done_man = 1'b1;
      @(negedge clk);
      done_man = 1'b0;
      chk("R9", "drive back on after done", drive_en, 1);
      wait_pen(1'b0, 40, n);
      chk("R8", "release after conversion completes", pen_down, 0);
      auto_done = 1'b1;
      repeat (5) @(negedge clk);

      // R10 disable while touched
      cfg_word = {8'd1, 8'd0, 8'd0, 8'd5};
      contact_raw = 1'b1;
      wait_pen(1'b1, 2000, n);
      repeat (3) @(negedge clk);
      ctl_en = 1'b0;
      #1;
      chk("R10", "drive off at disable", drive_en, 0);
      @(negedge clk);
      chk("R10", "pen up after disable", pen_down, 0);
      chk("R10", "up event on disable", pen_evt, 1);
      c0 = conv_cnt;
      repeat (100) @(negedge clk);
      chk("R10", "no conversions while disabled", conv_cnt, c0);
      chk("R10", "pen stays up while disabled", pen_down, 0);
      chk("R12", "no start pulse while pen up", conv_start, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule